// File: doc/BRIEF.md
# Host-Patchable Microcode Sequencer

This block is a small microprogrammed controller. A 256-entry by 16-bit control store sits in on-chip RAM. The engine fetches one word at a time into a pipeline register, and that register drives the logic under control. The next fetch address comes from the fetched word itself: an 8-bit base address, with up to seven of its low bits replaced by external condition inputs. This gives multi-way branching without an adder.

A host supervises the engine through a set of simple control pins. It can load or patch words in the store, stop the engine, advance it by one microinstruction and set the program counter to the entry point of any sequence held in the store. The whole pipeline word is always visible to the host. Several independent sequences can live in the store together. The host picks one by preloading the PC and then running or stepping.

Each microinstruction takes two clock cycles. The first cycle reads the store into the pipeline register. The second computes the next address into the PC. With this split the store is a plain synchronous-read RAM.

Top module: `useq_engine`

## Requirements
- R1: After reset, `halted` is 1, `pc_q` is 0, `pipe_q` is 0 and `wr_err` is 0.
- R2: A host write (`host_we` high for one cycle) made while halted stores `host_wdata` at `host_addr`. A later fetch from that address returns the new word.
- R3: A host write made while the engine is not halted leaves the store unchanged and sets `wr_err`. `wr_err` stays 1 until reset.
- R4: A rising edge on `host_step` while halted executes exactly one microinstruction. `pipe_q` takes the word at the old PC, `pc_q` takes that word's next address, and the engine is halted again three clock edges after the request. Holding `host_step` high executes only one microinstruction.
- R5: A `host_step` edge while the engine is running has no effect. The engine keeps running and its sequence is unchanged.
- R6: Microword layout: bits [15:8] are the base address, bits [7:5] are a count n (0 to 7), and bits [4:0] are control outputs. The next address is the base with its n low bits replaced by `cond_in[n-1:0]`. When n is 0, the next address is the base itself.
- R7: `host_pc_load` while halted sets the PC to `host_pc_value`. The next step or run fetches the word at that address, so no stale word is executed.
- R8: A rising edge on `host_run` starts continuous execution. `host_halt` stops it at the end of the current microinstruction, and from then on `pc_q` and `pipe_q` stay frozen while halted.
- R9: `ctrl_out` equals `pipe_q[4:0]` and `pipe_q` shows the whole current microword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_halt | input | 1 | Stop at the next instruction boundary |
| host_run | input | 1 | Rising edge starts continuous execution |
| host_step | input | 1 | Rising edge executes one instruction while halted |
| host_pc_load | input | 1 | Preload the PC while halted |
| host_pc_value | input | 8 | Value for the PC preload |
| host_we | input | 1 | Control-store write strobe |
| host_addr | input | 8 | Control-store write address |
| host_wdata | input | 16 | Control-store write data |
| cond_in | input | 8 | Branch condition inputs |
| pc_q | output | 8 | Program counter |
| pipe_q | output | 16 | Pipeline register (host readback) |
| ctrl_out | output | 5 | Control outputs of the current word |
| halted | output | 1 | Engine is halted |
| wr_err | output | 1 | Sticky flag: write attempted while busy |

## Verification
The hardest situation to reach is a host request that arrives while the engine is actually running. A busy write or a step pulse only lands in that window if a running program stays put. The stimulus therefore builds a short chain that ends in a word branching to itself. It starts that chain with a run edge, and then issues the busy write and the step while the PC sits on the self-loop. After a halt, the patched address is fetched to show the store kept its old word. Branch merging is swept over every count n and every condition value, each from a freshly preloaded PC.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    PH_HALT  = 2'd0,
    PH_FETCH = 2'd1,
    PH_SEQ   = 2'd2
  } phase_t;

endpackage

// File: rtl/useq_branch.sv
module useq_branch #(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic [ADDR_W+SEL_W-1:0] hdr,
  input  logic [ADDR_W-1:0]       cond,
  output logic [ADDR_W-1:0]       nxt
);

  logic [ADDR_W-1:0] base;
  logic [SEL_W-1:0]  nsel;

  assign base = hdr[ADDR_W+SEL_W-1:SEL_W];
  assign nsel = hdr[SEL_W-1:0];

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign nxt[i] = (int'(nsel) > i) ? cond[i] : base[i];
  end

endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] pipe_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        pipe_q <= '0;
    else if (rd_en) pipe_q <= mem[rd_addr];
  end

  assert_pipe_only_on_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(pipe_q));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              run_req,
  input  logic              step_req,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_value,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] pc_q,
  output logic              fetch_en,
  output logic              store_we,
  output logic              halted,
  output logic              busy_err
);

  phase_t phase;
  logic   run_mode;
  logic   step_d, run_d;
  logic   step_edge, run_edge;

  assign step_edge = step_req & ~step_d;
  assign run_edge  = run_req  & ~run_d;
  assign halted    = (phase == PH_HALT);
  assign fetch_en  = (phase == PH_FETCH);
  assign store_we  = host_we & halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_HALT;
      run_mode <= 1'b0;
      step_d   <= 1'b0;
      run_d    <= 1'b0;
      pc_q     <= '0;
      busy_err <= 1'b0;
    end else begin
      step_d <= step_req;
      run_d  <= run_req;
      if (halt_req)      run_mode <= 1'b0;
      else if (run_edge) run_mode <= 1'b1;
      if (host_we && !halted) busy_err <= 1'b1;
      unique case (phase)
        PH_HALT: begin
          if (pc_load) pc_q <= pc_value;
          if ((run_edge && !halt_req) || step_edge) phase <= PH_FETCH;
        end
        PH_FETCH: phase <= PH_SEQ;
        PH_SEQ: begin
          pc_q  <= nxt_addr;
          phase <= (run_mode && !halt_req) ? PH_FETCH : PH_HALT;
        end
        default: phase <= PH_HALT;
      endcase
    end
  end

  assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (halted && !pc_load) |=> $stable(pc_q));

  assert_step_starts_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (halted && step_edge) |=> (phase == PH_FETCH));

  assert_fetch_then_seq_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (phase == PH_SEQ));

  assert_err_raised_R3: assert property (@(posedge clk) disable iff (rst)
    (host_we && !halted) |=> busy_err);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    busy_err |=> busy_err);

endmodule

// File: rtl/useq_engine.sv
module useq_engine #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            host_halt,
  input  logic                            host_run,
  input  logic                            host_step,
  input  logic                            host_pc_load,
  input  logic [ADDR_W-1:0]               host_pc_value,
  input  logic                            host_we,
  input  logic [ADDR_W-1:0]               host_addr,
  input  logic [WORD_W-1:0]               host_wdata,
  input  logic [ADDR_W-1:0]               cond_in,
  output logic [ADDR_W-1:0]               pc_q,
  output logic [WORD_W-1:0]               pipe_q,
  output logic [WORD_W-ADDR_W-SEL_W-1:0]  ctrl_out,
  output logic                            halted,
  output logic                            wr_err
);

  localparam int CTRL_W = WORD_W - ADDR_W - SEL_W;

  logic              fetch_en;
  logic              store_we;
  logic [ADDR_W-1:0] nxt_addr;

  useq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .halt_req (host_halt),
    .run_req  (host_run),
    .step_req (host_step),
    .pc_load  (host_pc_load),
    .pc_value (host_pc_value),
    .host_we  (host_we),
    .nxt_addr (nxt_addr),
    .pc_q     (pc_q),
    .fetch_en (fetch_en),
    .store_we (store_we),
    .halted   (halted),
    .busy_err (wr_err)
  );

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (store_we),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .rd_en   (fetch_en),
    .rd_addr (pc_q),
    .pipe_q  (pipe_q)
  );

  useq_branch #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_branch (
    .hdr  (pipe_q[WORD_W-1:CTRL_W]),
    .cond (cond_in),
    .nxt  (nxt_addr)
  );

  assign ctrl_out = pipe_q[CTRL_W-1:0];

  assert_pipe_frozen_halted_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pipe_q));

endmodule

// File: tb/useq_engine_tb.sv
module useq_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_halt = 0, host_run = 0, host_step = 0, host_pc_load = 0, host_we = 0;
  logic [7:0]  host_pc_value = 0, host_addr = 0, cond_in = 0;
  logic [15:0] host_wdata = 0;
  logic [7:0]  pc_q;
  logic [15:0] pipe_q;
  logic [4:0]  ctrl_out;
  logic        halted, wr_err;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  useq_engine u_dut (
    .clk(clk), .rst(rst), .host_halt(host_halt), .host_run(host_run),
    .host_step(host_step), .host_pc_load(host_pc_load), .host_pc_value(host_pc_value),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .cond_in(cond_in), .pc_q(pc_q), .pipe_q(pipe_q), .ctrl_out(ctrl_out),
    .halted(halted), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkword(input logic [7:0] base, input int n, input logic [4:0] c);
    return {base, 3'(n), c};
  endfunction

  function automatic logic [7:0] expect_next(input logic [7:0] base, input int n, input logic [7:0] cond);
    logic [7:0] mask;
    mask = 8'((1 << n) - 1);
    return (base & ~mask) | (cond & mask);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic wait_halt();
    for (int k = 0; k < 20; k++) begin
      if (halted) break;
      @(negedge clk);
    end
  endtask

  task automatic step_from(input logic [7:0] a, input bit load);
    @(negedge clk); host_pc_load = load; host_pc_value = a; host_step = 1;
    @(negedge clk); host_pc_load = 0; host_step = 0;
    wait_halt();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual running expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] w;
    logic [15:0] loopw;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 halted", halted, 1);
    chk("R1 pc", pc_q, 0);
    chk("R1 pipe", pipe_q, 0);
    chk("R1 wr_err", wr_err, 0);

    // R6 R4 R7 R9: sweep every count and every condition value
    for (int n = 0; n < 8; n++) begin
      logic [7:0] base;
      logic [7:0] a;
      base = 8'hC3 ^ 8'(n * 41);
      a    = 8'h80 + 8'(n);
      w    = mkword(base, n, 5'(n * 3 + 1));
      wr(a, w);
      for (int c = 0; c < 256; c++) begin
        cond_in = 8'(c);
        step_from(a, 1);
        chk("R6 next address", pc_q, expect_next(base, n, 8'(c)));
        chk("R7 fetched word", pipe_q, w);
        chk("R9 ctrl_out", ctrl_out, w[4:0]);
        chk("R4 halted after step", halted, 1);
      end
    end
    cond_in = 8'h00;

    // R4 edge trigger: holding step executes only one word
    wr(8'h40, mkword(8'h41, 0, 5'h02));
    wr(8'h41, mkword(8'h42, 0, 5'h03));
    @(negedge clk); host_pc_load = 1; host_pc_value = 8'h40;
    @(negedge clk); host_pc_load = 0;
    host_step = 1;
    repeat (10) @(negedge clk);
    host_step = 0;
    wait_halt();
    chk("R4 held step pc", pc_q, 8'h41);
    chk("R4 held step pipe", pipe_q, mkword(8'h41, 0, 5'h02));

    // R2 prefill patch target
    wr(8'h30, 16'h5A5A);
    // chain 0x10 -> 0x11 -> 0x12 (self loop)
    loopw = mkword(8'h12, 0, 5'h1F);
    wr(8'h10, mkword(8'h11, 0, 5'h01));
    wr(8'h11, mkword(8'h12, 0, 5'h04));
    wr(8'h12, loopw);
    @(negedge clk); host_pc_load = 1; host_pc_value = 8'h10;
    @(negedge clk); host_pc_load = 0; host_run = 1;
    @(negedge clk); host_run = 0;
    repeat (20) @(negedge clk);
    // R8 running reaches the loop
    chk("R8 running", halted, 0);
    chk("R8 loop pc", pc_q, 8'h12);
    chk("R8 loop pipe", pipe_q, loopw);
    chk("R9 loop ctrl", ctrl_out, 5'h1F);
    // R3 busy write
    wr(8'h30, 16'hBEEF);
    chk("R3 wr_err set", wr_err, 1);
    // R5 step while running
    @(negedge clk); host_step = 1;
    @(negedge clk); host_step = 0;
    repeat (6) @(negedge clk);
    chk("R5 still running", halted, 0);
    chk("R5 pc unchanged", pc_q, 8'h12);
    // R8 halt
    @(negedge clk); host_halt = 1;
    @(negedge clk); host_halt = 0;
    wait_halt();
    chk("R8 halted", halted, 1);
    repeat (8) @(negedge clk);
    chk("R8 pc frozen", pc_q, 8'h12);
    chk("R8 pipe frozen", pipe_q, loopw);
    chk("R3 wr_err sticky", wr_err, 1);
    // R3 store untouched by busy write
    step_from(8'h30, 1);
    chk("R3 store unchanged", pipe_q, 16'h5A5A);
    // R2 halted patch takes effect
    wr(8'h30, 16'hBEEF);
    step_from(8'h30, 1);
    chk("R2 patched word", pipe_q, 16'hBEEF);
    chk("R3 wr_err still sticky", wr_err, 1);

    finish_run();
  end

endmodule